// File: doc/BRIEF.md
# Interrupt Source Routing Table Controller

This block keeps one routing entry for every logical interrupt source. An entry holds a valid bit, a masked bit, a destination queue index and a 32-bit event data word. Software-side agents send two kinds of command over a request/response handshake. A set command steers a source to a CPU target at a given priority, or parks it. A get command reports where a source is currently steered. Every command answers with a status code.

The destination queue index is computed from the target and the priority, so the table needs no separate queue allocator. A get command reads the queue's owner and priority back through a companion queue-descriptor read port, which a neighbouring queue block serves combinationally. The whole command set can be switched off with a mode-enable input. While it is off, every command is refused and no state changes.

Top module: `route_ctl`

## Requirements
- R1: Status codes are 0 success, 1 function-unavailable, 2 bad-parameter, 3 bad-source, 4 bad-target, 5 bad-priority. While `mode_en` is low during command execution, every command answers 1 and leaves the table unchanged.
- R2: For a set command, only flag bit 0 (mask) and flag bit 1 (load event data) may be set, counting from the LSB; any other set bit answers 2. For a get command, any non-zero flag answers 2.
- R3: A source number of `NUM_SRC` or above answers 3, and so does a source whose entry is not valid.
- R4: A set command with priority 0xFF answers 0. It leaves the entry valid and masked, with queue index 0 and event data 0.
- R5: A set command with a priority from 7 to 0xFE answers 5 and writes nothing.
- R6: A set command with a target of `NUM_CPUS` or above answers 4 and writes nothing. A good set stores the queue index target*8+priority, which is then presented on `qd_rd_idx` during a get of that source.
- R7: In a good set, flag bit 0 set makes the entry masked and flag bit 0 clear unmasks it. The event data is replaced only when flag bit 1 is set; otherwise the old value is kept.
- R8: A good get returns the target as the descriptor owner minus 0x400 and the stored event data. It returns priority 0xFF when the entry is masked, and otherwise the descriptor priority.
- R9: After reset, entries 0 to `NUM_CPUS`-1 are valid and masked with queue index 0 and data 0, and all other entries are invalid.
- R10: `req_ready` is high when idle and low for the one cycle after a request is accepted. `resp_valid` pulses for exactly one cycle, two clock edges after the accepting edge. Any response other than a get success carries zero target, priority and data.
- R11: Checks are applied in this order: mode, flags, source, then priority, then target. The first failing check sets the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Enables the command set |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_set | input | 1 | 1 set command, 0 get command |
| req_flags | input | FLAG_W | Command flags |
| req_src | input | SRCN_W | Logical source number |
| req_target | input | TGT_W | CPU target (set) |
| req_prio | input | 8 | Priority or 0xFF reset code (set) |
| req_data | input | DATA_W | Event data (set) |
| qd_rd_idx | output | QIDX_W | Queue-descriptor read index |
| qd_owner | input | TGT_W | Owner index of the addressed descriptor |
| qd_prio | input | 8 | Priority held in the addressed descriptor |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 3 | Status code |
| resp_target | output | TGT_W | Returned target |
| resp_prio | output | 8 | Returned priority |
| resp_data | output | DATA_W | Returned event data |

## Verification
A corrupted entry stays hidden until a get addresses that source. The flaw then shows in the same response, two edges after acceptance, as a wrong target or priority (from a bad queue index or mask bit), wrong data, or a bad-source status (from a lost valid bit). The bench therefore follows each kind of set with gets, and it sweeps every source so that a write reaching the wrong entry is caught when the neighbour is read back. Handshake faults appear on the next cycle, because ready and the strobe are compared against a behavioural model on every clock.

// File: rtl/route_pkg.sv
package route_pkg;

   typedef enum logic [2:0] {
      RS_OK       = 3'd0,
      RS_FUNC     = 3'd1,
      RS_PARAM    = 3'd2,
      RS_BAD_SRC  = 3'd3,
      RS_BAD_TGT  = 3'd4,
      RS_BAD_PRIO = 3'd5
   } route_status_e;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_EXEC = 1'b1
   } route_phase_e;

   localparam int          PRIO_W      = 8;
   localparam logic [7:0]  PRIO_RESET  = 8'hFF;
   localparam int          PRIO_USABLE = 7;
   localparam int          QPRIO_SHIFT = 3;
   localparam logic [31:0] OWNER_BASE  = 32'h0000_0400;
   localparam int          FL_MASK     = 0;
   localparam int          FL_DATA     = 1;

endpackage

// File: rtl/route_table.sv
module route_table #(
   parameter  int NUM_SRC  = 24,
   parameter  int NUM_CPUS = 6,
   parameter  int QIDX_W   = 6,
   parameter  int DATA_W   = 32,
   localparam int TIDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIDX_W-1:0] rd_idx,
   output logic              rd_valid,
   output logic              rd_masked,
   output logic [QIDX_W-1:0] rd_qidx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [TIDX_W-1:0] wr_idx,
   input  logic              wr_masked,
   input  logic [QIDX_W-1:0] wr_qidx,
   input  logic [DATA_W-1:0] wr_data
);

   logic [NUM_SRC-1:0] ent_valid;
   logic [NUM_SRC-1:0] ent_masked;
   logic [QIDX_W-1:0]  ent_qidx [NUM_SRC];
   logic [DATA_W-1:0]  ent_data [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      localparam bit BOOT_ON = (i < NUM_CPUS);
      logic              v_q;
      logic              m_q;
      logic [QIDX_W-1:0] q_q;
      logic [DATA_W-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= BOOT_ON;
            m_q <= BOOT_ON;
            q_q <= '0;
            d_q <= '0;
         end else if (wr_en && (wr_idx == TIDX_W'(i))) begin
            v_q <= 1'b1;
            m_q <= wr_masked;
            q_q <= wr_qidx;
            d_q <= wr_data;
         end
      end

      assign ent_valid[i]  = v_q;
      assign ent_masked[i] = m_q;
      assign ent_qidx[i]   = q_q;
      assign ent_data[i]   = d_q;
   end

   if ((1 << TIDX_W) == NUM_SRC) begin : g_rd_direct
      assign rd_valid  = ent_valid[rd_idx];
      assign rd_masked = ent_masked[rd_idx];
      assign rd_qidx   = ent_qidx[rd_idx];
      assign rd_data   = ent_data[rd_idx];
   end else begin : g_rd_guard
      logic in_rng;
      assign in_rng    = (32'(rd_idx) < NUM_SRC);
      assign rd_valid  = in_rng ? ent_valid[rd_idx]  : 1'b0;
      assign rd_masked = in_rng ? ent_masked[rd_idx] : 1'b0;
      assign rd_qidx   = in_rng ? ent_qidx[rd_idx]   : '0;
      assign rd_data   = in_rng ? ent_data[rd_idx]   : '0;
   end

endmodule

// File: rtl/route_check.sv
module route_check
   import route_pkg::*;
#(
   parameter int NUM_SRC  = 24,
   parameter int NUM_CPUS = 6,
   parameter int SRCN_W   = 16,
   parameter int TGT_W    = 32,
   parameter int FLAG_W   = 8
) (
   input  logic              mode_en,
   input  logic              is_set,
   input  logic [FLAG_W-1:0] flags,
   input  logic [SRCN_W-1:0] src,
   input  logic              entry_valid,
   input  logic [PRIO_W-1:0] prio,
   input  logic [TGT_W-1:0]  target,
   output route_status_e     status,
   output logic              reset_code
);

   localparam logic [FLAG_W-1:0] SET_ALLOWED = FLAG_W'((1 << FL_MASK) | (1 << FL_DATA));

   logic flag_bad, src_bad, prio_bad, tgt_bad;

   always_comb begin
      reset_code = (prio == PRIO_RESET);
      flag_bad   = is_set ? (|(flags & ~SET_ALLOWED)) : (|flags);
      src_bad    = (32'(src) >= NUM_SRC) || !entry_valid;
      prio_bad   = !reset_code && (prio >= PRIO_W'(PRIO_USABLE));
      tgt_bad    = (target >= TGT_W'(NUM_CPUS));

      if (!mode_en)          status = RS_FUNC;
      else if (flag_bad)     status = RS_PARAM;
      else if (src_bad)      status = RS_BAD_SRC;
      else if (!is_set)      status = RS_OK;
      else if (reset_code)   status = RS_OK;
      else if (prio_bad)     status = RS_BAD_PRIO;
      else if (tgt_bad)      status = RS_BAD_TGT;
      else                   status = RS_OK;
   end

endmodule

// File: rtl/route_ctl.sv
module route_ctl
   import route_pkg::*;
#(
   parameter  int NUM_SRC  = 24,
   parameter  int NUM_CPUS = 6,
   parameter  int SRCN_W   = 16,
   parameter  int TGT_W    = 32,
   parameter  int DATA_W   = 32,
   parameter  int FLAG_W   = 8,
   localparam int QIDX_W   = $clog2(NUM_CPUS * 8),
   localparam int TIDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_set,
   input  logic [FLAG_W-1:0] req_flags,
   input  logic [SRCN_W-1:0] req_src,
   input  logic [TGT_W-1:0]  req_target,
   input  logic [7:0]        req_prio,
   input  logic [DATA_W-1:0] req_data,
   output logic [QIDX_W-1:0] qd_rd_idx,
   input  logic [TGT_W-1:0]  qd_owner,
   input  logic [7:0]        qd_prio,
   output logic              resp_valid,
   output logic [2:0]        resp_status,
   output logic [TGT_W-1:0]  resp_target,
   output logic [7:0]        resp_prio,
   output logic [DATA_W-1:0] resp_data
);

   if (NUM_CPUS < 1 || NUM_SRC < NUM_CPUS || FLAG_W < 2 || SRCN_W < TIDX_W ||
       SRCN_W > 32 || TGT_W > 32 || TGT_W < QIDX_W + 1 || TGT_W < PRIO_W) begin : g_bad_cfg
      $error("route_ctl: parameter set out of range");
   end

   route_phase_e      phase;
   logic              cmd_set;
   logic [FLAG_W-1:0] cmd_flags;
   logic [SRCN_W-1:0] cmd_src;
   logic [TGT_W-1:0]  cmd_tgt;
   logic [7:0]        cmd_prio;
   logic [DATA_W-1:0] cmd_data;
   logic              accept;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cmd_set   <= 1'b0;
         cmd_flags <= '0;
         cmd_src   <= '0;
         cmd_tgt   <= '0;
         cmd_prio  <= '0;
         cmd_data  <= '0;
      end else begin
         phase <= accept ? PH_EXEC : PH_IDLE;
         if (accept) begin
            cmd_set   <= req_set;
            cmd_flags <= req_flags;
            cmd_src   <= req_src;
            cmd_tgt   <= req_target;
            cmd_prio  <= req_prio;
            cmd_data  <= req_data;
         end
      end
   end

   logic              rd_valid, rd_masked;
   logic [QIDX_W-1:0] rd_qidx;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en, wr_masked;
   logic [QIDX_W-1:0] wr_qidx;
   logic [DATA_W-1:0] wr_data;
   route_status_e     chk_status;
   logic              reset_code;

   route_table #(
      .NUM_SRC  (NUM_SRC),
      .NUM_CPUS (NUM_CPUS),
      .QIDX_W   (QIDX_W),
      .DATA_W   (DATA_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (cmd_src[TIDX_W-1:0]),
      .rd_valid  (rd_valid),
      .rd_masked (rd_masked),
      .rd_qidx   (rd_qidx),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_idx    (cmd_src[TIDX_W-1:0]),
      .wr_masked (wr_masked),
      .wr_qidx   (wr_qidx),
      .wr_data   (wr_data)
   );

   route_check #(
      .NUM_SRC  (NUM_SRC),
      .NUM_CPUS (NUM_CPUS),
      .SRCN_W   (SRCN_W),
      .TGT_W    (TGT_W),
      .FLAG_W   (FLAG_W)
   ) u_check (
      .mode_en     (mode_en),
      .is_set      (cmd_set),
      .flags       (cmd_flags),
      .src         (cmd_src),
      .entry_valid (rd_valid),
      .prio        (cmd_prio),
      .target      (cmd_tgt),
      .status      (chk_status),
      .reset_code  (reset_code)
   );

   assign qd_rd_idx = rd_qidx;

   always_comb begin
      wr_en = (phase == PH_EXEC) && cmd_set && (chk_status == RS_OK);
      if (reset_code) begin
         wr_masked = 1'b1;
         wr_qidx   = '0;
         wr_data   = '0;
      end else begin
         wr_masked = cmd_flags[FL_MASK];
         wr_qidx   = QIDX_W'((cmd_tgt << QPRIO_SHIFT) + TGT_W'(cmd_prio));
         wr_data   = cmd_flags[FL_DATA] ? cmd_data : rd_data;
      end
   end

   logic get_ok;
   assign get_ok = !cmd_set && (chk_status == RS_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_status <= 3'd0;
         resp_target <= '0;
         resp_prio   <= '0;
         resp_data   <= '0;
      end else begin
         resp_valid <= (phase == PH_EXEC);
         if (phase == PH_EXEC) begin
            resp_status <= chk_status;
            resp_target <= get_ok ? (qd_owner - TGT_W'(OWNER_BASE)) : '0;
            resp_prio   <= get_ok ? (rd_masked ? PRIO_RESET : qd_prio) : '0;
            resp_data   <= get_ok ? rd_data : '0;
         end
      end
   end

endmodule

// File: rtl/route_ctl_chk.sv
module route_ctl_chk
   import route_pkg::*;
#(
   parameter int NUM_CPUS = 6,
   parameter int QIDX_W   = 6,
   parameter int TGT_W    = 32,
   parameter int DATA_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_en,
   input logic              req_valid,
   input logic              req_ready,
   input logic [QIDX_W-1:0] qd_rd_idx,
   input logic              resp_valid,
   input logic [2:0]        resp_status,
   input logic [TGT_W-1:0]  resp_target,
   input logic [7:0]        resp_prio,
   input logic [DATA_W-1:0] resp_data
);

   AST_ACCEPT_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> ##2 resp_valid); // R10

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R10

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R10

   AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status != RS_OK) |->
         (resp_target == '0 && resp_prio == '0 && resp_data == '0)); // R10

   AST_DISABLED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !$past(mode_en)) |-> (resp_status == RS_FUNC)); // R1

   AST_QIDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(qd_rd_idx) < NUM_CPUS * 8); // R6

   AST_GET_PRIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status == RS_OK && resp_prio != PRIO_RESET) |->
         (resp_prio < 8'(PRIO_USABLE))); // R8

endmodule

bind route_ctl route_ctl_chk #(
   .NUM_CPUS (NUM_CPUS),
   .QIDX_W   (QIDX_W),
   .TGT_W    (TGT_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_en     (mode_en),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .qd_rd_idx   (qd_rd_idx),
   .resp_valid  (resp_valid),
   .resp_status (resp_status),
   .resp_target (resp_target),
   .resp_prio   (resp_prio),
   .resp_data   (resp_data)
);

// File: tb/route_ctl_tb.sv
module route_ctl_tb;

   localparam int NUM_SRC  = 24;
   localparam int NUM_CPUS = 6;
   localparam int SRCN_W   = 16;
   localparam int TGT_W    = 32;
   localparam int DATA_W   = 32;
   localparam int FLAG_W   = 8;
   localparam int QIDX_W   = $clog2(NUM_CPUS * 8);
   localparam int WDOG     = 100000;

   localparam logic [2:0] S_OK = 3'd0, S_FUNC = 3'd1, S_PARAM = 3'd2,
                          S_SRC = 3'd3, S_TGT = 3'd4, S_PRIO = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              mode_en = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_set = 1'b0;
   logic [FLAG_W-1:0] req_flags = '0;
   logic [SRCN_W-1:0] req_src = '0;
   logic [TGT_W-1:0]  req_target = '0;
   logic [7:0]        req_prio = '0;
   logic [DATA_W-1:0] req_data = '0;
   logic [QIDX_W-1:0] qd_rd_idx;
   logic [TGT_W-1:0]  qd_owner;
   logic [7:0]        qd_prio;
   logic              resp_valid;
   logic [2:0]        resp_status;
   logic [TGT_W-1:0]  resp_target;
   logic [7:0]        resp_prio;
   logic [DATA_W-1:0] resp_data;

   route_ctl #(
      .NUM_SRC  (NUM_SRC),
      .NUM_CPUS (NUM_CPUS),
      .SRCN_W   (SRCN_W),
      .TGT_W    (TGT_W),
      .DATA_W   (DATA_W),
      .FLAG_W   (FLAG_W)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_en     (mode_en),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_set     (req_set),
      .req_flags   (req_flags),
      .req_src     (req_src),
      .req_target  (req_target),
      .req_prio    (req_prio),
      .req_data    (req_data),
      .qd_rd_idx   (qd_rd_idx),
      .qd_owner    (qd_owner),
      .qd_prio     (qd_prio),
      .resp_valid  (resp_valid),
      .resp_status (resp_status),
      .resp_target (resp_target),
      .resp_prio   (resp_prio),
      .resp_data   (resp_data)
   );

   // companion queue descriptors: queue n belongs to CPU n/8 at priority n%8
   always_comb begin
      qd_owner = 32'h400 + 32'(qd_rd_idx >> 3);
      qd_prio  = 8'(qd_rd_idx[2:0]);
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // behavioural model
   bit          m_valid  [NUM_SRC];
   bit          m_masked [NUM_SRC];
   int          m_qidx   [NUM_SRC];
   logic [31:0] m_data   [NUM_SRC];

   int          exp_due = -10;
   logic [2:0]  e_st;
   logic [31:0] e_tgt;
   logic [7:0]  e_pr;
   logic [31:0] e_dat;
   string       e_tag = "";

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   bit ev, er;
   always @(negedge clk) begin
      if (rst_n) begin
         ev = (cyc == exp_due);
         er = (cyc != exp_due - 1);
         chk(resp_valid == ev, "R10", "resp_valid", 64'(resp_valid), 64'(ev));
         chk(req_ready == er, "R10", "req_ready", 64'(req_ready), 64'(er));
         if (ev) begin
            chk(resp_status == e_st,  e_tag, "status", 64'(resp_status), 64'(e_st));
            chk(resp_target == e_tgt, e_tag, "target", 64'(resp_target), 64'(e_tgt));
            chk(resp_prio == e_pr,    e_tag, "prio",   64'(resp_prio),   64'(e_pr));
            chk(resp_data == e_dat,   e_tag, "data",   64'(resp_data),   64'(e_dat));
         end
      end
   end

   task automatic issue(bit en, bit set, logic [7:0] fl, int src, logic [31:0] tgt,
                        logic [7:0] pr, logic [31:0] dat, string tag);
      @(posedge clk); #2;
      mode_en    = en;
      req_valid  = 1'b1;
      req_set    = set;
      req_flags  = fl;
      req_src    = 16'(src);
      req_target = tgt;
      req_prio   = pr;
      req_data   = dat;
      e_tgt = '0; e_pr = '0; e_dat = '0;
      if (!en) e_st = S_FUNC;
      else if (set ? ((fl & 8'hFC) != 0) : (fl != 0)) e_st = S_PARAM;
      else if (src >= NUM_SRC || !m_valid[src]) e_st = S_SRC;
      else if (!set) begin
         e_st  = S_OK;
         e_tgt = 32'(m_qidx[src] / 8);
         e_pr  = m_masked[src] ? 8'hFF : 8'(m_qidx[src] % 8);
         e_dat = m_data[src];
      end else if (pr == 8'hFF) begin
         e_st = S_OK;
         m_masked[src] = 1'b1;
         m_qidx[src]   = 0;
         m_data[src]   = '0;
      end else if (pr >= 8'd7) e_st = S_PRIO;
      else if (tgt >= 32'(NUM_CPUS)) e_st = S_TGT;
      else begin
         e_st = S_OK;
         m_masked[src] = fl[0];
         m_qidx[src]   = int'(tgt) * 8 + int'(pr);
         if (fl[1]) m_data[src] = dat;
      end
      e_tag   = tag;
      exp_due = cyc + 2;
      @(posedge clk); #2;
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk); #1;
   endtask

   task automatic get(int src, string tag);
      issue(1'b1, 1'b0, 8'h00, src, 32'h0, 8'h00, 32'h0, tag);
   endtask

   task automatic put(bit [7:0] fl, int src, int tgt, logic [7:0] pr, logic [31:0] dat, string tag);
      issue(1'b1, 1'b1, fl, src, 32'(tgt), pr, dat, tag);
   endtask

   always @(posedge clk) begin
      if (cyc > WDOG) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NUM_SRC; i++) begin
         m_valid[i]  = (i < NUM_CPUS);
         m_masked[i] = (i < NUM_CPUS);
         m_qidx[i]   = 0;
         m_data[i]   = '0;
      end
      repeat (3) @(posedge clk);
      #5;
      chk(resp_valid == 1'b0, "R9", "resp_valid in reset", 64'(resp_valid), 64'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      chk(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);

      // R9 reset contents
      for (int s = 0; s < NUM_CPUS; s++) get(s, "R9");
      get(NUM_CPUS, "R9");
      get(NUM_SRC - 1, "R9");
      get(NUM_SRC, "R3");
      get(16'hFFFF, "R3");

      // R1 disabled mode
      issue(1'b0, 1'b1, 8'h02, 1, 32'd2, 8'd3, 32'h1234, "R1");
      issue(1'b0, 1'b0, 8'h00, 1, 32'd0, 8'd0, 32'h0, "R1");
      get(1, "R1");

      // R6 R7 good set with data, then read back
      put(8'h02, 1, 2, 8'd3, 32'hABCD_0001, "R6");
      get(1, "R8");

      // R2 flags
      put(8'h04, 1, 0, 8'd0, 32'h5, "R2");
      put(8'h80, 1, 0, 8'd0, 32'h5, "R2");
      issue(1'b1, 1'b0, 8'h01, 1, 32'd0, 8'd0, 32'h0, "R2");
      get(1, "R2");

      // R5 reserved priorities
      put(8'h02, 1, 0, 8'd7, 32'h9, "R5");
      put(8'h02, 1, 0, 8'hFE, 32'h9, "R5");
      put(8'h00, 1, 0, 8'h80, 32'h9, "R5");
      get(1, "R5");

      // R6 bad target
      put(8'h02, 1, NUM_CPUS, 8'd0, 32'h9, "R6");
      put(8'h02, 1, 32'h0000_0400, 8'd0, 32'h9, "R6");
      get(1, "R6");

      // R7 mask keeps data, unmask moves target
      put(8'h01, 1, 2, 8'd3, 32'hDEAD, "R7");
      get(1, "R7");
      put(8'h00, 1, 3, 8'd6, 32'hDEAD, "R7");
      get(1, "R7");
      put(8'h03, 1, 3, 8'd6, 32'hBEEF, "R7");
      get(1, "R7");

      // R4 reset code
      put(8'h00, 1, 99, 8'hFF, 32'h0, "R4");
      get(1, "R4");
      put(8'h02, 1, 1, 8'd0, 32'h77, "R4");
      get(1, "R4");

      // R3 invalid entry
      put(8'h00, NUM_CPUS + 2, 0, 8'd0, 32'h1, "R3");
      put(8'h00, NUM_SRC, 0, 8'd0, 32'h1, "R3");

      // R11 ordering
      put(8'h08, NUM_SRC, 0, 8'd9, 32'h1, "R11");
      put(8'h00, NUM_SRC, 99, 8'd9, 32'h1, "R11");
      put(8'h00, 2, 99, 8'd9, 32'h1, "R11");
      issue(1'b0, 1'b1, 8'hF0, NUM_SRC, 32'd99, 8'd9, 32'h1, "R11");

      // boundaries: smallest and largest queue index
      put(8'h02, 0, 0, 8'd0, 32'hFFFF_FFFF, "R6");
      get(0, "R6");
      put(8'h02, 5, NUM_CPUS - 1, 8'd6, 32'h0, "R6");
      get(5, "R6");

      // sweep over every source, then read back each one
      for (int s = 0; s < NUM_SRC + 2; s++)
         put(8'(s % 4), s, s % NUM_CPUS, 8'(s % 7), 32'(s) * 32'h1111, "R6");
      for (int s = 0; s < NUM_SRC + 2; s++) get(s, "R8");

      repeat (3) @(posedge clk);
      #5;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule